// File: doc/BRIEF.md
# Keyed Windowed Watchdog

This block supervises a processor through an 8-bit service register. Software proves it is alive by writing a byte that carries a fixed key, a window-select code and a clock-monitor enable flag. The block counts pulses of an idle-timer tick. A write counts as a valid service only if it arrives inside the open service window and its fields match. A valid service restarts the window. A write that comes too early, no write before the window closes, or a write whose fields do not match pulls the active-low watchdog output low for a fixed number of ticks. After that time the output is released.

The first write after reset works differently. It needs only the correct key, may arrive at any point in the maximum window, and sets the window select and the monitor flag for the rest of the run. Those fields are locked from then on. During halt and idle the detector is inhibited and the window counter is held at zero, so the window starts afresh when the mode ends. The register port and the mode and tick inputs are plain control signals with no handshake: a write is taken in the cycle in which its strobe is high.

Top module: `wdog_keyed`

## Requirements
- R1: After reset the watchdog output is high and the register reads 0xC1: window select 11 (maximum window) and monitor enable 1.
- R2: Register layout is bits [7:6] window select, bits [5:1] key, bit [0] monitor enable. The key field always reads as 00000.
- R3: The first write after reset is valid if its key field equals 01100, whatever the tick count. It loads the window select and monitor enable. If the key field differs, the write is an error.
- R4: Once the first valid write has been taken, any later write is an error unless its key, window select and monitor enable all match. The stored window select and monitor enable never change again.
- R5: After the first valid write, a write that arrives while fewer than 2048 ticks have been counted since the window started is an error.
- R6: Window-select codes 00, 01, 10 and 11 give upper limits of 8192, 16384, 32768 and 65536 ticks. If no write is taken first, the tick that brings the count to the limit causes an error. A write in the same cycle as that tick is judged as a service and does not time out.
- R7: On an error, the output goes low at the next clock edge. It stays low for exactly 16 ticks, then goes high, and the window restarts from zero.
- R8: Writes made while the output is low are ignored. They change neither the stored fields nor the release time.
- R9: While halt or idle is high, no error is raised, writes are ignored and the window count is held at zero. The window restarts when the mode ends.
- R10: A valid service restarts the window count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Idle-timer tick, one pulse per counted tick |
| halt_i | input | 1 | Halt mode, inhibits the detector |
| idle_i | input | 1 | Idle mode, inhibits the detector |
| svc_wr_i | input | 1 | Service register write strobe |
| svc_wdata_i | input | 8 | Service register write data |
| svc_rdata_o | output | 8 | Service register readback, key field masked |
| wdog_n_o | output | 1 | Watchdog output, low while an error is held |

## Verification
Two functions can fall in the same clock edge: a service write, and the tick that brings the count to the upper limit. The bench waits exactly one tick short of the limit and then writes in the cycle in which that last tick arrives; the output must stay high. A second run without the write must see the output fall on that edge. The lower edge of the window is provoked in the same way, with writes at 2047 and at 2048 ticks, and the result is judged by the level of the output one edge after the write.

// File: rtl/wdog_keyed_pkg.sv
package wdog_keyed_pkg;

  localparam int unsigned WD_SEL_W = 2;
  localparam int unsigned WD_KEY_W = 5;
  localparam int unsigned WD_REG_W = WD_SEL_W + WD_KEY_W + 1;

  localparam logic [WD_KEY_W-1:0] WD_KEY_CODE = 5'b01100;

  typedef struct packed {
    logic [WD_SEL_W-1:0] win_sel;
    logic                mon_en;
  } wd_cfg_t;

  localparam wd_cfg_t WD_CFG_RESET = '{win_sel: '1, mon_en: 1'b1};

endpackage

// File: rtl/wdog_cfg_reg.sv
module wdog_cfg_reg
  import wdog_keyed_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                commit_i,
  input  wd_cfg_t             new_cfg_i,
  output wd_cfg_t             cfg_o,
  output logic                locked_o,
  output logic [WD_REG_W-1:0] rdata_o
);

  wd_cfg_t cfg_q;
  logic    locked_q;

  // Fields are loaded only by the first valid service; afterwards they are frozen.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q    <= WD_CFG_RESET;
      locked_q <= 1'b0;
    end else if (commit_i && !locked_q) begin
      cfg_q    <= new_cfg_i;
      locked_q <= 1'b1;
    end
  end

  assign cfg_o    = cfg_q;
  assign locked_o = locked_q;
  // The key never appears on readback.
  assign rdata_o  = {cfg_q.win_sel, {WD_KEY_W{1'b0}}, cfg_q.mon_en};

endmodule

// File: rtl/wdog_svc_check.sv
module wdog_svc_check
  import wdog_keyed_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned LOWER_TICKS = 2048
)(
  input  logic [WD_REG_W-1:0] wdata_i,
  input  wd_cfg_t             cfg_i,
  input  logic                locked_i,
  input  logic [CNT_W-1:0]    cnt_i,
  output wd_cfg_t             new_cfg_o,
  output logic                good_o
);

  localparam logic [CNT_W-1:0] LOWER_BOUND = CNT_W'(LOWER_TICKS);

  logic [WD_SEL_W-1:0] w_sel;
  logic [WD_KEY_W-1:0] w_key;
  logic                w_mon;
  logic                key_ok;
  logic                field_ok;
  logic                time_ok;

  always_comb begin
    w_sel = wdata_i[WD_REG_W-1 -: WD_SEL_W];
    w_key = wdata_i[WD_KEY_W:1];
    w_mon = wdata_i[0];
    key_ok = (w_key == WD_KEY_CODE);
    // Before the lock only the key matters; after it every field and the lower bound count.
    if (locked_i) begin
      field_ok = (w_sel == cfg_i.win_sel) && (w_mon == cfg_i.mon_en);
      time_ok  = (cnt_i >= LOWER_BOUND);
    end else begin
      field_ok = 1'b1;
      time_ok  = 1'b1;
    end
    good_o            = key_ok && field_ok && time_ok;
    new_cfg_o.win_sel = w_sel;
    new_cfg_o.mon_en  = w_mon;
  end

endmodule

// File: rtl/wdog_window_cnt.sv
module wdog_window_cnt
  import wdog_keyed_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned MIN_LOG2  = 13
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear_i,
  input  logic                tick_i,
  input  logic [WD_SEL_W-1:0] sel_i,
  output logic [CNT_W-1:0]    cnt_o,
  output logic                at_limit_o
);

  localparam int unsigned NSEL = 1 << WD_SEL_W;

  logic [CNT_W-1:0] last_tab [NSEL];
  logic [CNT_W-1:0] cnt_q;

  // Last count before expiry for each select code: 2^(MIN_LOG2+code) - 1.
  for (genvar g = 0; g < NSEL; g++) begin : g_limit
    localparam logic [CNT_W:0] LIMIT = (CNT_W+1)'(1) << (MIN_LOG2 + g);
    assign last_tab[g] = CNT_W'(LIMIT - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o      = cnt_q;
  assign at_limit_o = (cnt_q == last_tab[sel_i]);

endmodule

// File: rtl/wdog_hold.sv
module wdog_hold #(
  parameter int unsigned HOLD_TICKS = 16
)(
  input  logic clk,
  input  logic rst_n,
  input  logic trip_i,
  input  logic tick_i,
  output logic wdog_n_o
);

  localparam int unsigned HW = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_TICKS - 1);

  logic [HW-1:0] hcnt_q;
  logic          out_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q  <= 1'b1;
      hcnt_q <= '0;
    end else if (out_q) begin
      if (trip_i) begin
        out_q  <= 1'b0;
        hcnt_q <= '0;
      end
    end else if (tick_i) begin
      if (hcnt_q == HOLD_LAST) begin
        out_q <= 1'b1;
      end else begin
        hcnt_q <= hcnt_q + 1'b1;
      end
    end
  end

  assign wdog_n_o = out_q;

endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_keyed_pkg::*;
#(
  parameter int unsigned LOWER_TICKS = 2048,
  parameter int unsigned MIN_LOG2    = 13,
  parameter int unsigned HOLD_TICKS  = 16
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                halt_i,
  input  logic                idle_i,
  input  logic                svc_wr_i,
  input  logic [WD_REG_W-1:0] svc_wdata_i,
  output logic [WD_REG_W-1:0] svc_rdata_o,
  output logic                wdog_n_o
);

  localparam int unsigned CNT_W = MIN_LOG2 + (1 << WD_SEL_W) - 1;

  wd_cfg_t          cfg;
  wd_cfg_t          new_cfg;
  logic             cfg_locked;
  logic [CNT_W-1:0] win_cnt;
  logic             at_limit;
  logic             svc_good;
  logic             active;
  logic             armed;
  logic             svc_fire;
  logic             commit;
  logic             expire;
  logic             trip;
  logic             win_clear;

  always_comb begin
    active    = !halt_i && !idle_i;
    armed     = active && wdog_n_o;
    svc_fire  = svc_wr_i && armed;
    commit    = svc_fire && svc_good;
    // A write on the limit tick is judged as a service, not as a timeout.
    expire    = armed && tick_i && at_limit && !svc_fire;
    trip      = (svc_fire && !svc_good) || expire;
    win_clear = !armed || svc_fire || expire;
  end

  wdog_cfg_reg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit_i  (commit),
    .new_cfg_i (new_cfg),
    .cfg_o     (cfg),
    .locked_o  (cfg_locked),
    .rdata_o   (svc_rdata_o)
  );

  wdog_svc_check #(
    .CNT_W       (CNT_W),
    .LOWER_TICKS (LOWER_TICKS)
  ) u_check (
    .wdata_i   (svc_wdata_i),
    .cfg_i     (cfg),
    .locked_i  (cfg_locked),
    .cnt_i     (win_cnt),
    .new_cfg_o (new_cfg),
    .good_o    (svc_good)
  );

  wdog_window_cnt #(
    .CNT_W    (CNT_W),
    .MIN_LOG2 (MIN_LOG2)
  ) u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (win_clear),
    .tick_i     (tick_i),
    .sel_i      (cfg.win_sel),
    .cnt_o      (win_cnt),
    .at_limit_o (at_limit)
  );

  wdog_hold #(
    .HOLD_TICKS (HOLD_TICKS)
  ) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .trip_i   (trip),
    .tick_i   (tick_i),
    .wdog_n_o (wdog_n_o)
  );

endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned LOWER_TICKS = 2048
)(
  input logic             clk,
  input logic             rst_n,
  input logic             halt_i,
  input logic             idle_i,
  input logic             svc_wr_i,
  input logic [7:0]       svc_rdata_o,
  input logic             wdog_n_o,
  input logic             locked,
  input logic [CNT_W-1:0] win_cnt
);

  p_key_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    svc_rdata_o[5:1] == 5'b00000);

  p_lock_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> $stable(svc_rdata_o));

  p_early_error_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_wr_i && wdog_n_o && !halt_i && !idle_i && locked &&
     (win_cnt < CNT_W'(LOWER_TICKS))) |=> !wdog_n_o);

  p_hold_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdog_n_o) |=> !wdog_n_o);

  p_held_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdog_n_o && svc_wr_i) |=> $stable(svc_rdata_o));

  p_inhibit_no_error_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((halt_i || idle_i) && wdog_n_o) |=> wdog_n_o);

  p_inhibit_count_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_i || idle_i) |=> (win_cnt == '0));

endmodule

bind wdog_keyed wdog_keyed_chk #(
  .CNT_W       (CNT_W),
  .LOWER_TICKS (LOWER_TICKS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .halt_i      (halt_i),
  .idle_i      (idle_i),
  .svc_wr_i    (svc_wr_i),
  .svc_rdata_o (svc_rdata_o),
  .wdog_n_o    (wdog_n_o),
  .locked      (cfg_locked),
  .win_cnt     (win_cnt)
);

// File: tb/wdog_keyed_tb.sv
module wdog_keyed_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       halt = 1'b0;
  logic       idle = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       wdog_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdog_keyed u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick),
    .halt_i      (halt),
    .idle_i      (idle),
    .svc_wr_i    (wr),
    .svc_wdata_i (wdata),
    .svc_rdata_o (rdata),
    .wdog_n_o    (wdog_n)
  );

  // Vector: {service first with 0x19, ticks to wait, data written, error expected}
  localparam int NV = 10;
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 16'd0,     8'h19, 1'b0},  // R3 first service at count 0
    {1'b0, 16'd5,     8'h1B, 1'b1},  // R3 first service, wrong key
    {1'b1, 16'd100,   8'h19, 1'b1},  // R5 early
    {1'b1, 16'd2047,  8'h19, 1'b1},  // R5 one tick early
    {1'b1, 16'd2048,  8'h19, 1'b0},  // R5 first legal tick
    {1'b1, 16'd8191,  8'h19, 1'b0},  // R6 write on limit tick wins
    {1'b1, 16'd3000,  8'h59, 1'b1},  // R4 window field mismatch
    {1'b1, 16'd3000,  8'h18, 1'b1},  // R4 monitor field mismatch
    {1'b1, 16'd3000,  8'h1D, 1'b1},  // R4 key mismatch
    {1'b0, 16'd12000, 8'hD9, 1'b0}   // R3 late first service inside max window
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    halt  = 1'b0;
    idle  = 1'b0;
    wr    = 1'b0;
    rst_n = 1'b0;
    cyc(2);
    rst_n = 1'b1;
  endtask

  task automatic svc(input logic [7:0] d);
    wr    = 1'b1;
    wdata = d;
    cyc(1);
    wr    = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    #2;
    // R1 reset state
    do_reset();
    chk("R1 output after reset", wdog_n, 1);
    chk("R1 readback after reset", rdata, 8'hC1);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      do_reset();
      if (VEC[i][25]) svc(8'h19);
      cyc(int'(VEC[i][24:9]));
      svc(VEC[i][8:1]);
      chk($sformatf("R3/R4/R5/R6 vector %0d output", i), wdog_n, !VEC[i][0]);
    end

    // R2 readback masks key; R3 loads fields
    do_reset();
    svc(8'h59);
    chk("R2 R3 readback after first service", rdata, 8'h41);

    // R4 lock: matching later service fine, mismatch errors, fields unchanged
    do_reset();
    svc(8'h19);
    cyc(3000);
    svc(8'h19);
    chk("R4 R10 matching service", wdog_n, 1);
    cyc(3000);
    svc(8'hD9);
    chk("R4 mismatch error", wdog_n, 0);
    chk("R4 fields frozen", rdata, 8'h01);

    // R6 timeout at 8192, R7 hold length, R8 ignored writes
    do_reset();
    svc(8'h19);
    cyc(8191);
    chk("R6 high one tick before limit", wdog_n, 1);
    cyc(1);
    chk("R6 timeout at limit", wdog_n, 0);
    svc(8'h19);
    chk("R8 write during hold ignored", wdog_n, 0);
    chk("R8 fields unchanged during hold", rdata, 8'h01);
    cyc(14);
    chk("R7 still low after 15 ticks", wdog_n, 0);
    cyc(1);
    chk("R7 released after 16 ticks", wdog_n, 1);
    cyc(2048);
    svc(8'h19);
    chk("R7 window restarted on release", wdog_n, 1);

    // R6 16k window
    do_reset();
    svc(8'h59);
    cyc(16383);
    chk("R6 16k window high before limit", wdog_n, 1);
    cyc(1);
    chk("R6 16k window timeout", wdog_n, 0);

    // R9 halt inhibits and restarts the window
    do_reset();
    svc(8'h19);
    cyc(3000);
    halt = 1'b1;
    cyc(9000);
    chk("R9 no timeout during halt", wdog_n, 1);
    svc(8'h00);
    chk("R9 bad write ignored during halt", wdog_n, 1);
    chk("R9 fields unchanged during halt", rdata, 8'h01);
    halt = 1'b0;
    cyc(2000);
    svc(8'h19);
    chk("R9 window restarted after halt", wdog_n, 0);

    // R9 idle exit restarts the window
    do_reset();
    svc(8'h19);
    cyc(5000);
    idle = 1'b1;
    cyc(10);
    idle = 1'b0;
    cyc(2048);
    svc(8'h19);
    chk("R9 R10 service after idle exit", wdog_n, 1);

    // R1 R6 maximum window before first service
    do_reset();
    cyc(65535);
    chk("R1 R6 max window high before limit", wdog_n, 1);
    cyc(1);
    chk("R1 R6 max window timeout", wdog_n, 0);

    finish_run();
  end

endmodule